// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block keeps recent translations from linear page numbers to physical frame numbers, so that most memory references can skip the two-level page-table walk. A lookup presents a 32-bit linear address together with a request strobe. In the same cycle the block answers with a hit flag, the 32-bit physical address and the three permission bits held for that page: user/supervisor, read/write and dirty. Pages are 4 KiB. The low 12 address bits go straight through as the offset, and the upper 20 bits form the page number that is matched against the cache.

The cache holds 32 entries, arranged as 8 sets of 4 ways. After a walk finishes, the walker writes the new translation through a fill port. Inside a set, a 3-bit pseudo-LRU tree picks the way to replace, but an empty way is always used before any valid way is evicted. If the filled page is already cached, its entry is overwritten in place. A flush input invalidates the whole cache in a single cycle. The table walk, the bus, segmentation and the handling of faults are all outside this block. The reset input is active low, asserts asynchronously and must be released synchronously to `clk` by the reset network.

Top module: `ptc_top`

## Requirements
- R1: During reset and after it, every entry is invalid, so every lookup misses until a fill has been accepted.
- R2: The page number is lookup address bits [31:12]. Bits [14:12] select the set and bits [31:15] are the tag. A hit needs a valid entry in the selected set whose full 20-bit page number is equal.
- R3: On a hit in the same cycle, `lkp_paddr` is {stored frame number, lookup address bits [11:0]}, and `lkp_user`, `lkp_write` and `lkp_dirty` show the stored bits.
- R4: When there is no hit, `lkp_paddr` is zero and all three permission outputs are 0. This includes cycles where `lkp_req` is low.
- R5: An accepted fill is visible to lookups from the next cycle onward. A lookup made in the same cycle as the fill sees the contents from before the fill.
- R6: A fill whose page number is already cached rewrites that way's frame number and permission bits. No second entry is created.
- R7: A fill of a new page into a set that has an invalid way goes into the lowest-numbered invalid way.
- R8: Each set has three replacement bits: root, low-pair and high-pair. Root 0 picks ways 0/1 and root 1 picks ways 2/3. In the chosen pair, a bit of 0 picks the lower way. Any hit or fill of way w sets the bits to point away from w. Reset and flush clear all three bits to 0. A fill of a new page into a full set replaces the way the bits select.
- R9: When `flush` is high, every entry is invalidated at the next edge and all replacement bits are cleared. A lookup in that cycle misses, and a fill in that cycle is dropped.
- R10: If a lookup hit and a fill fall in the same set in the same cycle, only the fill's way updates that set's replacement bits.
- R11: All 32 entries can hold distinct pages at the same time: four fills into each of the 8 sets all stay resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| lkp_req | input | 1 | Lookup strobe |
| lkp_addr | input | 32 | Linear address to translate |
| lkp_hit | output | 1 | Translation found |
| lkp_paddr | output | 32 | Physical address on hit, zero otherwise |
| lkp_user | output | 1 | Stored user/supervisor bit on hit |
| lkp_write | output | 1 | Stored read/write bit on hit |
| lkp_dirty | output | 1 | Stored dirty bit on hit |
| fill_req | input | 1 | Write a translation |
| fill_vpn | input | 20 | Page number being filled |
| fill_pfn | input | 20 | Frame number for that page |
| fill_user | input | 1 | User/supervisor bit to store |
| fill_write | input | 1 | Read/write bit to store |
| fill_dirty | input | 1 | Dirty bit to store |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench goes after each corner case below, and each one shows up at the outputs if the design gets it wrong:

- Pages that differ only in their tag bits. A design that compares too few bits would report false hits.
- Eviction after a hit has moved the tree. A wrong tree update would evict a recently used page and keep a stale one.
- A refill of a page that is already cached. A design that allocates again would hold duplicates, return stale frame numbers, or lose a neighbour to the eviction.
- Lookups and fills in the same cycle as a flush, and lookup/fill collisions in one set. A design that mishandles these would leak a hit through the flush, keep the dropped fill, or let the lookup override the replacement update.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef struct packed {
    logic user;
    logic write;
    logic dirty;
  } ptc_perm_t;
endpackage

// File: rtl/ptc_match.sv
module ptc_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 17,
  localparam int WIDX = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic [WIDX-1:0]            hit_way,
  output logic                       hit_any
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WIDX'(w);
    end
  end

  assign hit_any = |hit_vec;
endmodule

// File: rtl/ptc_plru.sv
module ptc_plru #(
  parameter int WAYS  = 4,
  localparam int WIDX = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            acc_en,
  input  logic [WIDX-1:0] acc_way,
  output logic [WIDX-1:0] victim
);
  // tree nodes in heap order: node 1 is the root, children of n are 2n and 2n+1
  logic [WAYS-1:1] tree_q, tree_d;
  logic            tree_en;
  logic [WIDX:0]   leaf;
  logic [WIDX:0]   node;

  assign leaf    = {1'b1, acc_way};
  assign tree_en = clr || acc_en;

  always_comb begin
    tree_d = tree_q;
    if (clr) begin
      tree_d = '0;
    end else if (acc_en) begin
      for (int l = 0; l < WIDX; l++) begin
        tree_d[int'(leaf >> (WIDX - l))] = ~leaf[WIDX-1-l];
      end
    end
  end

  always_comb begin
    node = (WIDX+1)'(1);
    for (int l = 0; l < WIDX; l++) begin
      node = {node[WIDX-1:0], tree_q[int'(node)]};
    end
    victim = node[WIDX-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tree_q <= '0;
    else if (tree_en) tree_q <= tree_d;
  end

  p_victim_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !clr) |=> (victim != $past(acc_way)));
endmodule

// File: rtl/ptc_top.sv
module ptc_top
  import ptc_pkg::*;
#(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int PFN_W = 20,
  localparam int VPN_W = VA_W - OFS_W,
  localparam int PA_W  = PFN_W + OFS_W,
  localparam int SIDX  = $clog2(SETS),
  localparam int WIDX  = $clog2(WAYS),
  localparam int TAG_W = VPN_W - SIDX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_req,
  input  logic [VA_W-1:0]  lkp_addr,
  output logic             lkp_hit,
  output logic [PA_W-1:0]  lkp_paddr,
  output logic             lkp_user,
  output logic             lkp_write,
  output logic             lkp_dirty,
  input  logic             fill_req,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_user,
  input  logic             fill_write,
  input  logic             fill_dirty,
  input  logic             flush
);
  // storage: valid bits reset, payload written only on fill
  logic [SETS-1:0][WAYS-1:0]            valid_q, valid_d;
  logic                                 valid_en;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][PFN_W-1:0] pfn_q;
  ptc_perm_t [SETS-1:0][WAYS-1:0]       perm_q;

  // lookup side
  logic [VPN_W-1:0] lk_vpn;
  logic [SIDX-1:0]  lk_set;
  logic [TAG_W-1:0] lk_tag;
  logic [WAYS-1:0]  lk_vec;
  logic [WIDX-1:0]  lk_way;
  logic             lk_any, lk_go;
  ptc_perm_t        lk_perm;

  assign lk_vpn = lkp_addr[VA_W-1:OFS_W];
  assign lk_set = lk_vpn[SIDX-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:SIDX];

  ptc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid   (valid_q[lk_set]),
    .tags    (tag_q[lk_set]),
    .tag     (lk_tag),
    .hit_vec (lk_vec),
    .hit_way (lk_way),
    .hit_any (lk_any)
  );

  assign lk_go     = lkp_req && !flush && lk_any;
  assign lk_perm   = perm_q[lk_set][lk_way];
  assign lkp_hit   = lk_go;
  assign lkp_paddr = lk_go ? {pfn_q[lk_set][lk_way], lkp_addr[OFS_W-1:0]} : '0;
  assign lkp_user  = lk_go && lk_perm.user;
  assign lkp_write = lk_go && lk_perm.write;
  assign lkp_dirty = lk_go && lk_perm.dirty;

  // fill side
  logic [SIDX-1:0]  fl_set;
  logic [TAG_W-1:0] fl_tag;
  logic [WAYS-1:0]  fl_vec;
  logic [WIDX-1:0]  fl_mway, fl_iway, fl_way;
  logic             fl_any, fl_inv, fl_go;
  logic [SETS-1:0][WIDX-1:0] vict;

  assign fl_set = fill_vpn[SIDX-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:SIDX];
  assign fl_go  = fill_req && !flush;

  ptc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .valid   (valid_q[fl_set]),
    .tags    (tag_q[fl_set]),
    .tag     (fl_tag),
    .hit_vec (fl_vec),
    .hit_way (fl_mway),
    .hit_any (fl_any)
  );

  always_comb begin
    fl_iway = '0;
    fl_inv  = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[fl_set][w]) begin
        fl_iway = WIDX'(w);
        fl_inv  = 1'b1;
      end
    end
  end

  assign fl_way = fl_any ? fl_mway : (fl_inv ? fl_iway : vict[fl_set]);

  // replacement trees, one per set; fill owns the update on a set collision
  logic [SETS-1:0]           acc_en;
  logic [SETS-1:0][WIDX-1:0] acc_way;

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      acc_en[s]  = (fl_go && fl_set == SIDX'(s)) || (lk_go && lk_set == SIDX'(s));
      acc_way[s] = (fl_go && fl_set == SIDX'(s)) ? fl_way : lk_way;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    ptc_plru #(.WAYS(WAYS)) u_plru (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (flush),
      .acc_en  (acc_en[s]),
      .acc_way (acc_way[s]),
      .victim  (vict[s])
    );
  end

  // valid next state
  assign valid_en = flush || fl_go;

  always_comb begin
    valid_d = valid_q;
    if (flush)      valid_d = '0;
    else if (fl_go) valid_d[fl_set][fl_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        valid_q <= '0;
    else if (valid_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fl_go) begin
      tag_q[fl_set][fl_way]  <= fl_tag;
      pfn_q[fl_set][fl_way]  <= fill_pfn;
      perm_q[fl_set][fl_way] <= '{user: fill_user, write: fill_write, dirty: fill_dirty};
    end
  end

  // assertions
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |-> $onehot0(lk_vec));

  p_fill_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> $onehot0(fl_vec));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lkp_hit);

  p_fill_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_go |=> (!(lkp_req && !flush && lk_vpn == $past(fill_vpn)) || lkp_hit));

  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> (lkp_paddr[OFS_W-1:0] == lkp_addr[OFS_W-1:0]));
endmodule

// File: tb/tb_ptc_top.sv
`timescale 1ns/1ps
module tb_ptc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lkp_req;
  logic [31:0] lkp_addr;
  logic        lkp_hit;
  logic [31:0] lkp_paddr;
  logic        lkp_user, lkp_write, lkp_dirty;
  logic        fill_req;
  logic [19:0] fill_vpn, fill_pfn;
  logic        fill_user, fill_write, fill_dirty;
  logic        flush;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ptc_top dut (
    .clk, .rst_n, .lkp_req, .lkp_addr, .lkp_hit, .lkp_paddr,
    .lkp_user, .lkp_write, .lkp_dirty, .fill_req, .fill_vpn, .fill_pfn,
    .fill_user, .fill_write, .fill_dirty, .flush
  );

  // behavioural model
  bit       m_v    [8][4];
  int       m_vpn  [8][4];
  int       m_pfn  [8][4];
  bit [2:0] m_perm [8][4];
  bit       m_root [8];
  bit       m_lo   [8];
  bit       m_hi   [8];

  function automatic int pick_victim(int s);
    if (!m_root[s]) return m_lo[s] ? 1 : 0;
    return m_hi[s] ? 3 : 2;
  endfunction

  function automatic void touch(int s, int w);
    if (w < 2) begin m_root[s] = 1; m_lo[s] = (w == 0); end
    else       begin m_root[s] = 0; m_hi[s] = (w == 2); end
  endfunction

  function automatic void model_clear();
    for (int s = 0; s < 8; s++) begin
      m_root[s] = 0; m_lo[s] = 0; m_hi[s] = 0;
      for (int w = 0; w < 4; w++) m_v[s][w] = 0;
    end
  endfunction

  task automatic check(string req, bit ok, string act, string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic step(string req, bit lreq, logic [31:0] la, bit freq,
                      logic [19:0] fv, logic [19:0] fp, bit [2:0] fperm, bit fl);
    bit exp_hit; int ew, ls, fs, fw;
    bit [31:0] exp_pa; bit [2:0] exp_perm;
    lkp_req = lreq; lkp_addr = la; fill_req = freq; fill_vpn = fv; fill_pfn = fp;
    {fill_user, fill_write, fill_dirty} = fperm; flush = fl;
    #1;
    exp_hit = 0; ew = 0; ls = int'(la[14:12]);
    if (lreq && !fl)
      for (int w = 0; w < 4; w++)
        if (m_v[ls][w] && m_vpn[ls][w] == int'(la[31:12])) begin exp_hit = 1; ew = w; end
    exp_pa   = exp_hit ? {m_pfn[ls][ew][19:0], la[11:0]} : 32'h0;
    exp_perm = exp_hit ? m_perm[ls][ew] : 3'b000;
    check(req, lkp_hit === exp_hit && lkp_paddr === exp_pa &&
               {lkp_user, lkp_write, lkp_dirty} === exp_perm,
          $sformatf("hit=%0b pa=%h perm=%b", lkp_hit, lkp_paddr, {lkp_user, lkp_write, lkp_dirty}),
          $sformatf("hit=%0b pa=%h perm=%b", exp_hit, exp_pa, exp_perm));
    @(posedge clk);
    if (fl) model_clear();
    else begin
      fs = int'(fv[2:0]);
      if (freq) begin
        fw = -1;
        for (int w = 0; w < 4; w++) if (m_v[fs][w] && m_vpn[fs][w] == int'(fv)) fw = w;
        if (fw < 0) for (int w = 3; w >= 0; w--) if (!m_v[fs][w]) fw = w;
        if (fw < 0) fw = pick_victim(fs);
        m_v[fs][fw] = 1; m_vpn[fs][fw] = int'(fv); m_pfn[fs][fw] = int'(fp); m_perm[fs][fw] = fperm;
        touch(fs, fw);
      end
      if (exp_hit && !(freq && fs == ls)) touch(ls, ew);
    end
    @(negedge clk);
  endtask

  task automatic look(string req, logic [19:0] v, logic [11:0] ofs);
    step(req, 1, {v, ofs}, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(string req, logic [19:0] v, logic [19:0] p, bit [2:0] pm);
    step(req, 0, 0, 1, v, p, pm, 0);
  endtask

  function automatic logic [19:0] pg(int tag, int set);
    return 20'((tag << 3) | set);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int hits;
    rst_n = 0; lkp_req = 1; lkp_addr = 32'h1234_5678; fill_req = 0; fill_vpn = 0;
    fill_pfn = 0; fill_user = 0; fill_write = 0; fill_dirty = 0; flush = 0;
    model_clear();
    repeat (3) @(negedge clk);
    #1;
    check("R1", lkp_hit === 1'b0 && lkp_paddr === 32'h0, $sformatf("hit=%0b", lkp_hit), "hit=0");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    look("R1", 20'h12345, 12'h678);
    look("R4", 20'h00000, 12'h000);
    step("R4", 0, 32'hABCDE123, 0, 0, 0, 0, 0);

    // R5: same-cycle lookup sees old state, next cycle hits; R3 fields
    step("R5", 1, {pg(5, 1), 12'h3A4}, 1, pg(5, 1), 20'hBEEF1, 3'b101, 0);
    look("R3", pg(5, 1), 12'h3A4);
    look("R3", pg(5, 1), 12'hFFF);
    look("R2", pg(5, 1) ^ 20'h80000, 12'h3A4);
    look("R2", pg(5, 2), 12'h3A4);
    look("R2", pg(4, 1), 12'h000);

    // R7: invalid ways filled lowest first
    for (int k = 0; k < 4; k++) fill("R7", pg(16 + k, 2), 20'(32'h100 + k), 3'(k));
    for (int k = 0; k < 4; k++) look("R7", pg(16 + k, 2), 12'(k * 16));

    // R8: full set, a hit steers the victim
    for (int k = 0; k < 4; k++) fill("R8", pg(40 + k, 3), 20'(32'h300 + k), 3'b010);
    look("R8", pg(42, 3), 12'h010);
    fill("R8", pg(44, 3), 20'h30A, 3'b111);
    for (int k = 0; k < 5; k++) look("R8", pg(40 + k, 3), 12'h020);
    fill("R8", pg(45, 3), 20'h30B, 3'b001);
    for (int k = 0; k < 6; k++) look("R8", pg(40 + k, 3), 12'h030);

    // R6: refill of a present page rewrites in place
    fill("R6", pg(41, 3), 20'hAAAAA, 3'b100);
    for (int k = 0; k < 6; k++) look("R6", pg(40 + k, 3), 12'h040);
    fill("R6", pg(46, 3), 20'h30C, 3'b000);
    for (int k = 0; k < 7; k++) look("R6", pg(40 + k, 3), 12'h050);

    // R10: hit and fill in the same set, same cycle
    step("R10", 1, {pg(41, 3), 12'h060}, 1, pg(47, 3), 20'h30D, 3'b011, 0);
    fill("R10", pg(48, 3), 20'h30E, 3'b011);
    for (int k = 40; k < 49; k++) look("R10", pg(k, 3), 12'h070);

    // R9: flush with a lookup and a fill in the same cycle
    step("R9", 1, {pg(5, 1), 12'h111}, 1, pg(9, 6), 20'h99999, 3'b111, 1);
    look("R9", pg(5, 1), 12'h111);
    look("R9", pg(9, 6), 12'h000);
    for (int k = 0; k < 4; k++) look("R9", pg(16 + k, 2), 12'h000);
    fill("R9", pg(50, 4), 20'h44444, 3'b010);
    fill("R9", pg(51, 4), 20'h44445, 3'b010);
    fill("R9", pg(52, 4), 20'h44446, 3'b010);
    fill("R9", pg(53, 4), 20'h44447, 3'b010);
    fill("R9", pg(54, 4), 20'h44448, 3'b010);
    for (int k = 50; k < 55; k++) look("R9", pg(k, 4), 12'h000);

    // R11: all 32 entries resident at once
    step("R11", 0, 0, 0, 0, 0, 0, 1);
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++) fill("R11", pg(100 + k, s), 20'(s * 16 + k), 3'(s));
    hits = 0;
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 4; k++) begin
        look("R11", pg(100 + k, s), 12'h5A5);
        if (lkp_hit === 1'b1) hits++;
      end
    check("R11", hits == 32, $sformatf("hits=%0d", hits), "hits=32");

    // mixed traffic over a small page pool that forces evictions in two sets
    for (int n = 0; n < 600; n++) begin
      int a, b;
      a = int'($urandom_range(0, 11));
      b = int'($urandom_range(0, 11));
      step("R8", $urandom_range(0, 3) != 0, {pg(200 + a, a % 2), 12'($urandom)},
           $urandom_range(0, 2) == 0, pg(200 + b, b % 2), 20'($urandom),
           3'($urandom), $urandom_range(0, 49) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule